// File: doc/BRIEF.md
# PCIe Configuration Window Base Decoder

This block is a single 64-bit register that places a memory-mapped PCIe configuration window. Software writes it with byte enables and reads it back whole. From the stored value the block derives three registered outputs: a flag saying the window is live, the window's base address aligned to the selected size, and the window size in bytes.

Three things feed the decode. The lowest bit turns the window on. A two-bit size code picks 256 MB, 128 MB or 64 MB, and its fourth value is reserved and shuts the window. The base is taken from a band of address bits whose lower edge moves down as the window shrinks. Each write with at least one byte lane enabled stores the merged value and refreshes the outputs at the same clock edge. Downstream logic that routes accesses into the window uses the outputs as they are.

Top module: `cfgwin_decoder`

## Requirements
- R1: After reset, readback equals `RST_VAL`, which defaults to 0x00000000_B0000000. Because bit 0 of that value is clear, `win_valid` is 0. `win_base` is 0xB0000000 and `win_len` is 0x10000000.
- R2: On a write, each byte lane i whose `wr_be[i]` is set takes `wr_data[8i+7:8i]`. Every other byte keeps its old value. `rd_data` always returns all 64 stored bits.
- R3: Bit 0 is the enable. While it is 0, `win_valid` is 0 whatever the size code holds.
- R4: Bits 2:1 are the size code. Code 00 gives `win_len` 0x10000000, code 01 gives 0x08000000 and code 10 gives 0x04000000. With bit 0 set, each of these codes drives `win_valid` to 1.
- R5: `win_base` is the stored value ANDed with a mask. For code 00 the mask is bits 35:28. Code 01 adds bit 27 and code 10 adds bits 27 and 26. Every other bit of `win_base` is 0.
- R6: Code 11 is reserved. It forces `win_valid` to 0 and `win_len` to 0, even with bit 0 set, and `win_base` uses the 256 MB mask.
- R7: Outputs and readback change at the clock edge that samples `wr_en` with a nonzero `wr_be`, so they are visible in the cycle after the strobe and not before it. A strobe with `wr_be` equal to 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 8 | Byte-lane enables for the write |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Stored register value |
| win_valid | output | 1 | Window enabled with a legal size code |
| win_base | output | 64 | Aligned window base address |
| win_len | output | ALIGN_LO+1 | Window size in bytes, 0 when the code is reserved |

## Verification
The bench builds the block with its default parameters: address top bit 35, largest-window alignment at bit 28, and a reset value that parks a disabled 256 MB window at 0xB0000000. With these values all four size codes are reachable. So are both extra mask bits, 27 and 26. Fully set write data also shows that bits above 35 and below the selected alignment never reach the base. Single-lane writes into byte 4 show that a partial write moves the base through the merge path.

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder #(
  parameter int          ADDR_HI  = 35,
  parameter int          ALIGN_LO = 28,
  parameter logic [63:0] RST_VAL  = 64'h0000_0000_B000_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [7:0]          wr_be,
  input  logic [63:0]         wr_data,
  output logic [63:0]         rd_data,
  output logic                win_valid,
  output logic [63:0]         win_base,
  output logic [ALIGN_LO:0]   win_len
);
  localparam int          LEN_W    = ALIGN_LO + 1;
  localparam logic [63:0] MASK_BIG = ((64'd1 << (ADDR_HI + 1)) - 64'd1) & ~((64'd1 << ALIGN_LO) - 64'd1);
  localparam logic [63:0] MASK_MID = MASK_BIG | (64'd1 << (ALIGN_LO - 1));
  localparam logic [63:0] MASK_SML = MASK_MID | (64'd1 << (ALIGN_LO - 2));

  function automatic logic [63:0] size_mask(input logic [1:0] code);
    case (code)
      2'b01:   return MASK_MID;
      2'b10:   return MASK_SML;
      default: return MASK_BIG;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] size_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return LEN_W'(1) << ALIGN_LO;
      2'b01:   return LEN_W'(1) << (ALIGN_LO - 1);
      2'b10:   return LEN_W'(1) << (ALIGN_LO - 2);
      default: return '0;
    endcase
  endfunction

  logic [63:0] cfg_q;
  logic [63:0] merged;
  logic        wr_hit;

  assign wr_hit  = wr_en && (wr_be != 8'h00);
  assign rd_data = cfg_q;

  always_comb begin
    merged = cfg_q;
    for (int i = 0; i < 8; i++)
      if (wr_be[i]) merged[8*i +: 8] = wr_data[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= RST_VAL;
      win_valid <= RST_VAL[0] && (RST_VAL[2:1] != 2'b11);
      win_base  <= RST_VAL & size_mask(RST_VAL[2:1]);
      win_len   <= size_bytes(RST_VAL[2:1]);
    end else if (wr_hit) begin
      cfg_q     <= merged;
      win_valid <= merged[0] && (merged[2:1] != 2'b11);
      win_base  <= merged & size_mask(merged[2:1]);
      win_len   <= size_bytes(merged[2:1]);
    end
  end

  p_valid_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> rd_data[0]);

  p_base_in_band_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_base & ~MASK_SML) == 64'd0);

  p_base_low_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[2:1] == 2'b00) |-> (win_base[ALIGN_LO-1:ALIGN_LO-2] == 2'b00));

  p_reserved_shut_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[2:1] == 2'b11) |-> (!win_valid && win_len == '0));

  p_len_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_len));

  p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_be != 8'h00) |=> ($stable(rd_data) && $stable(win_base) && $stable(win_valid)));

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[0]) |=> (rd_data[7:0] == $past(wr_data[7:0])));
endmodule

// File: tb/cfgwin_decoder_tb.sv
module cfgwin_decoder_tb;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_be = 8'h00;
  logic [63:0] wr_data = 64'd0;
  logic [63:0] rd_data;
  logic        win_valid;
  logic [63:0] win_base;
  logic [28:0] win_len;

  int applied = 0;
  int bad = 0;
  logic [63:0] shadow = 64'h0000_0000_B000_0000;

  always #(CLK_NS/2) clk = ~clk;

  cfgwin_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .win_valid(win_valid), .win_base(win_base), .win_len(win_len)
  );

  function automatic logic [63:0] exp_base(input logic [63:0] r);
    logic [63:0] m = 64'h0000_000F_F000_0000;
    if (r[2:1] == 2'b01) m |= 64'h0000_0000_0800_0000;
    if (r[2:1] == 2'b10) m |= 64'h0000_0000_0C00_0000;
    return r & m;
  endfunction

  function automatic logic [63:0] exp_len(input logic [63:0] r);
    case (r[2:1])
      2'b00: return 64'h1000_0000;
      2'b01: return 64'h0800_0000;
      2'b10: return 64'h0400_0000;
      default: return 64'h0;
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    applied++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, "readback", rd_data, shadow);
    check(req, "valid", {63'd0, win_valid}, {63'd0, shadow[0] && shadow[2:1] != 2'b11});
    check(req, "base", win_base, exp_base(shadow));
    check(req, "len", {35'd0, win_len}, exp_len(shadow));
  endtask

  task automatic do_write(input logic [7:0] be, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 8'h00;
    for (int i = 0; i < 8; i++)
      if (be[i]) shadow[8*i +: 8] = d[8*i +: 8];
  endtask

  task automatic t_reset;
    check("R1", "reset readback", rd_data, 64'h0000_0000_B000_0000);
    check("R1", "reset valid", {63'd0, win_valid}, 64'd0);
    check("R1", "reset base", win_base, 64'hB000_0000);
    check("R1", "reset len", {35'd0, win_len}, 64'h1000_0000);
  endtask

  task automatic t_enable;
    do_write(8'h01, 64'h01);
    check("R3", "enabled valid", {63'd0, win_valid}, 64'd1);
    check_all("R3");
    do_write(8'h01, 64'h00);
    check("R3", "disabled valid", {63'd0, win_valid}, 64'd0);
    check_all("R3");
  endtask

  task automatic t_sizes;
    do_write(8'hFF, 64'hFFFF_FFFF_FFFF_FFF1);
    check("R4", "256M len", {35'd0, win_len}, 64'h1000_0000);
    check("R5", "256M base", win_base, 64'h0000_000F_F000_0000);
    do_write(8'hFF, 64'hFFFF_FFFF_FFFF_FFF3);
    check("R4", "128M len", {35'd0, win_len}, 64'h0800_0000);
    check("R5", "128M base", win_base, 64'h0000_000F_F800_0000);
    check_all("R4");
    do_write(8'hFF, 64'hFFFF_FFFF_FFFF_FFF5);
    check("R4", "64M len", {35'd0, win_len}, 64'h0400_0000);
    check("R5", "64M base", win_base, 64'h0000_000F_FC00_0000);
    check_all("R5");
  endtask

  task automatic t_reserved;
    do_write(8'h01, 64'h07);
    check("R6", "reserved valid", {63'd0, win_valid}, 64'd0);
    check("R6", "reserved len", {35'd0, win_len}, 64'd0);
    check("R6", "reserved base", win_base, 64'h0000_000F_F000_0000);
  endtask

  task automatic t_merge;
    do_write(8'hFF, 64'h0000_0000_C000_0001);
    do_write(8'h10, 64'hAAAA_AAAA_AAAA_AAAA);
    check("R2", "lane4 merge", rd_data, 64'h0000_00AA_C000_0001);
    check("R2", "merged base", win_base, 64'h0000_000A_C000_0000);
    check_all("R2");
  endtask

  task automatic t_timing;
    @(negedge clk);
    wr_en = 1'b1; wr_be = 8'h0F; wr_data = 64'h0000_0000_4000_0003;
    #1;
    check("R7", "no early update", rd_data, shadow);
    @(negedge clk);
    wr_en = 1'b0; wr_be = 8'h00;
    shadow[31:0] = 32'h4000_0003;
    check_all("R7");
    do_write(8'h00, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R7", "empty be readback", rd_data, 64'h0000_00AA_4000_0003);
    check_all("R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_sizes();
    t_reserved();
    t_merge();
    t_timing();
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 20000);
    applied++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule